// File: doc/BRIEF.md
# Transmit Frame Transfer Sequencer

This block sits between a packet queue in buffer memory and the byte-wide transmit port of a token-ring MAC. For every packet in the queue it sends one framed burst of typed transfers on that port. The burst opens with a start marker. The packet's bytes follow one at a time, with the opaque request header first and the frame body after it. A closing marker ends the burst. Between bursts, and whenever no packet is being sent, the block fills each cycle with idle transfers.

The MAC slows the data phase by pulling a ready input low. While ready is low, the current data byte is shown again on each cycle, and nothing moves forward until ready is seen high. The start and closing markers ignore ready. The closing marker carries a hint bit that tells the MAC whether another frame is expected soon. The queue supplies that hint.

The queue hands over one word per pop. Each word carries a byte, an end-of-packet flag, a void flag that marks an empty packet, and the next-packet-pending hint. Once the first word of a non-empty packet is offered, the remaining words of that packet must be available one after another.

Top module: `tx_xfer_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `xfer_type` is 00 (idle fill), `xfer_more` is 0, and `q_pop` stays 0 while `q_valid` is low.
- R2: `xfer_type` uses the codes 00 idle fill, 01 start, 10 data and 11 end. Idle fill is shown on every cycle in which no packet is being sent.
- R3: Each non-empty packet produces exactly one start, then one data transfer per byte, then exactly one end. No idle fill is ever shown from a start up to and including its end.
- R4: After an end, at least GAP_MIN idle fills (1 to 8, default 2) come before the next start. Once GAP_MIN fills have been shown and a non-empty packet is offered, the very next transfer is the start. So no more than 8 fills come before a waiting frame.
- R5: When a data transfer is on the port and `txrdy` is low at the clock edge, the next cycle repeats the data transfer with the same byte. Bytes leave in queue order, unmodified, with none lost or duplicated. Header bytes are handled exactly like frame bytes.
- R6: `txrdy` does not hold a start or an end. A start is always followed on the next cycle by the first data transfer, and the accepted final byte is always followed on the next cycle by the end, whatever the level of `txrdy`.
- R7: `xfer_more` is high only with an end transfer. It equals the `q_more` value present in the cycle in which the final byte was accepted.
- R8: A word offered with `q_void` high is popped during idle fill without any start, data or end being issued, and the idle fill continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | 1 | Queue presents a word |
| q_data | input | DW | Packet byte |
| q_last | input | 1 | Word is the final byte of its packet |
| q_void | input | 1 | Word stands for an empty packet |
| q_more | input | 1 | Another packet will follow soon |
| q_pop | output | 1 | Queue word is consumed at this edge |
| txrdy | input | 1 | MAC is ready to accept the shown data byte |
| xfer_type | output | 2 | Transfer type code |
| xfer_data | output | DW | Transfer byte |
| xfer_more | output | 1 | More-frames hint, valid with the end code |

## Verification
The bench sends a run of packets whose lengths go from zero to six. It varies the idle time before each packet and drops `txrdy` at three densities, so that stalls land on header bytes, on final bytes and next to the start and end markers. A design that advanced on a stall would lose or skip a byte, and one that let `txrdy` gate a marker would repeat a start or delay an end. An off-by-one in the gap counter would show up as a start issued too early, or as an extra fill while a packet is waiting. A void word that was handled like a packet would produce a stray start followed directly by an end. A hint latched one cycle late would give the wrong bit, because `q_more` changes from word to word.

// File: rtl/tx_xfer_pkg.sv
package tx_xfer_pkg;
  typedef enum logic [1:0] {
    XT_FILL  = 2'b00,
    XT_START = 2'b01,
    XT_DATA  = 2'b10,
    XT_END   = 2'b11
  } xfer_t;
endpackage

// File: rtl/tx_gap_ctr.sv
module tx_gap_ctr #(
  parameter int GAP_MIN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fill_next,
  output logic gap_ok
);
  localparam int CW = $clog2(GAP_MIN + 2);
  localparam logic [CW-1:0] LIMIT = CW'(GAP_MIN);

  logic [CW-1:0] cnt;

  // counts idle fills shown since the last end, saturating at the limit
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= LIMIT;
    end else if (!fill_next) begin
      cnt <= '0;
    end else if (cnt < LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign gap_ok = (cnt >= LIMIT);

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);
endmodule

// File: rtl/tx_xfer_fsm.sv
module tx_xfer_fsm
  import tx_xfer_pkg::*;
(
  input  xfer_t cur_type,
  input  logic  cur_last,
  input  logic  gap_ok,
  input  logic  q_valid,
  input  logic  q_void,
  input  logic  q_more,
  input  logic  txrdy,
  output xfer_t nxt_type,
  output logic  load,
  output logic  pop,
  output logic  nxt_more
);
  always_comb begin
    nxt_type = XT_FILL;
    load     = 1'b0;
    pop      = 1'b0;
    nxt_more = 1'b0;
    unique case (cur_type)
      XT_FILL: begin
        if (gap_ok && q_valid) begin
          if (q_void) begin
            pop = 1'b1;
          end else begin
            nxt_type = XT_START;
          end
        end
      end
      XT_START: begin
        nxt_type = XT_DATA;
        load     = q_valid;
        pop      = q_valid;
      end
      XT_DATA: begin
        nxt_type = XT_DATA;
        if (txrdy) begin
          if (cur_last) begin
            nxt_type = XT_END;
            nxt_more = q_more;
          end else if (q_valid) begin
            load = 1'b1;
            pop  = 1'b1;
          end
        end
      end
      XT_END: nxt_type = XT_FILL;
      default: nxt_type = XT_FILL;
    endcase
  end
endmodule

// File: rtl/tx_xfer_oreg.sv
module tx_xfer_oreg
  import tx_xfer_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  xfer_t         nxt_type,
  input  logic          load,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  input  logic          nxt_more,
  output xfer_t         cur_type,
  output logic [DW-1:0] cur_data,
  output logic          cur_last,
  output logic          cur_more
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_type <= XT_FILL;
      cur_more <= 1'b0;
      cur_last <= 1'b0;
    end else begin
      cur_type <= nxt_type;
      cur_more <= nxt_more;
      if (load) cur_last <= in_last;
    end
  end

  // data path without reset so it maps onto plain flops
  always_ff @(posedge clk) begin
    if (load) cur_data <= in_data;
  end

  p_hint_end_r7: assert property (@(posedge clk) disable iff (rst)
    cur_more |-> (cur_type == XT_END));
endmodule

// File: rtl/tx_xfer_seq.sv
module tx_xfer_seq
  import tx_xfer_pkg::*;
#(
  parameter int DW      = 8,
  parameter int GAP_MIN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          q_valid,
  input  logic [DW-1:0] q_data,
  input  logic          q_last,
  input  logic          q_void,
  input  logic          q_more,
  output logic          q_pop,
  input  logic          txrdy,
  output logic [1:0]    xfer_type,
  output logic [DW-1:0] xfer_data,
  output logic          xfer_more
);
  xfer_t cur_type, nxt_type;
  logic  cur_last, gap_ok, load, nxt_more;

  tx_gap_ctr #(.GAP_MIN(GAP_MIN)) u_gap (
    .clk       (clk),
    .rst       (rst),
    .fill_next (nxt_type == XT_FILL),
    .gap_ok    (gap_ok)
  );

  tx_xfer_fsm u_fsm (
    .cur_type (cur_type),
    .cur_last (cur_last),
    .gap_ok   (gap_ok),
    .q_valid  (q_valid),
    .q_void   (q_void),
    .q_more   (q_more),
    .txrdy    (txrdy),
    .nxt_type (nxt_type),
    .load     (load),
    .pop      (q_pop),
    .nxt_more (nxt_more)
  );

  tx_xfer_oreg #(.DW(DW)) u_oreg (
    .clk      (clk),
    .rst      (rst),
    .nxt_type (nxt_type),
    .load     (load),
    .in_data  (q_data),
    .in_last  (q_last),
    .nxt_more (nxt_more),
    .cur_type (cur_type),
    .cur_data (xfer_data),
    .cur_last (cur_last),
    .cur_more (xfer_more)
  );

  assign xfer_type = cur_type;

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (xfer_type == XT_DATA && !txrdy) |=> (xfer_type == XT_DATA && $stable(xfer_data)));

  p_no_fill_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
    (xfer_type == XT_START || xfer_type == XT_DATA) |=> (xfer_type != XT_FILL));

  p_start_once_r6: assert property (@(posedge clk) disable iff (rst)
    (xfer_type == XT_START) |=> (xfer_type == XT_DATA));

  p_gap_start_r4: assert property (@(posedge clk) disable iff (rst)
    (xfer_type == XT_FILL && gap_ok && q_valid && !q_void) |=> (xfer_type == XT_START));

  p_void_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (xfer_type == XT_FILL && q_valid && q_void) |=> (xfer_type == XT_FILL));

  p_end_then_fill_r4: assert property (@(posedge clk) disable iff (rst)
    (xfer_type == XT_END) |=> (xfer_type == XT_FILL));
endmodule

// File: tb/tx_xfer_seq_tb.sv
module tx_xfer_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 8;
  localparam int GAP  = 2;
  localparam int NPKT = 60;
  localparam int WDOG = 20000;

  logic clk = 1'b0;
  logic rst;
  logic q_valid, q_last, q_void, q_more, q_pop, txrdy, xfer_more;
  logic [DW-1:0] q_data, xfer_data;
  logic [1:0] xfer_type;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_xfer_seq #(.DW(DW), .GAP_MIN(GAP)) u_dut (
    .clk(clk), .rst(rst), .q_valid(q_valid), .q_data(q_data), .q_last(q_last),
    .q_void(q_void), .q_more(q_more), .q_pop(q_pop), .txrdy(txrdy),
    .xfer_type(xfer_type), .xfer_data(xfer_data), .xfer_more(xfer_more)
  );

  int checks = 0;
  int failures = 0;

  function automatic int plen(int p);
    return p % 7;
  endfunction

  function automatic logic [DW-1:0] pbyte(int p, int i);
    return DW'((p * 29 + i * 11 + 3) & 8'hFF);
  endfunction

  function automatic int next_full(int p);
    int q = p;
    while (q < NPKT && plen(q) == 0) q++;
    return q;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // queue model state
  int pk = 0, wi = 0, hold = 0;
  // scoreboard state
  int eb_pk, eb_i = 0, starts = 0, ends = 0, fcnt, nfull = 0;
  bit frame_done = 0, pend_pop = 0;
  logic [1:0] p_type;
  logic [DW-1:0] p_data;
  bit p_rdy, p_qmore, p_qv, p_void;
  int p_fcnt;
  logic [15:0] lfsr = 16'hACE1;

  initial begin
    int cyc = 0;
    bit finished = 0;
    for (int p = 0; p < NPKT; p++) if (plen(p) != 0) nfull++;
    eb_pk = next_full(0);

    rst = 1'b1; q_valid = 0; q_data = '0; q_last = 0; q_void = 0; q_more = 0; txrdy = 0;
    repeat (3) @(negedge clk);
    chk(xfer_type == 2'b00, "R1 reset type", xfer_type, 0);
    chk(xfer_more == 1'b0, "R1 reset hint", xfer_more, 0);
    chk(q_pop == 1'b0, "R1 reset pop", q_pop, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(xfer_type == 2'b00, "R1 first cycle after reset", xfer_type, 0);
    p_type = 2'b00; p_data = '0; p_rdy = 0; p_qmore = 0; p_qv = 0; p_void = 0;
    fcnt = GAP + 1; p_fcnt = fcnt;

    while (!finished && cyc < WDOG) begin
      // outputs of the latest edge were formed from the p_* inputs
      if (p_type == 2'b10 && p_rdy) begin
        chk(eb_pk < NPKT && p_data == pbyte(eb_pk, eb_i), "R5 byte order", p_data,
            (eb_pk < NPKT) ? pbyte(eb_pk, eb_i) : -1);
        eb_i++;
        if (eb_pk < NPKT && eb_i == plen(eb_pk)) begin
          frame_done = 1; eb_i = 0; eb_pk = next_full(eb_pk + 1);
        end
      end
      if (p_type == 2'b10 && !p_rdy)
        chk(xfer_type == 2'b10 && xfer_data == p_data, "R5 stall repeat", xfer_data, p_data);
      if (p_type == 2'b01)
        chk(xfer_type == 2'b10, "R6 start then data", xfer_type, 2);
      if (xfer_type == 2'b00)
        chk(p_type != 2'b01 && p_type != 2'b10, "R3 fill inside frame", p_type, 0);
      if (p_type == 2'b11)
        chk(xfer_type == 2'b00, "R4 end then fill", xfer_type, 0);
      if (p_type == 2'b00 && p_fcnt >= GAP && p_qv && !p_void)
        chk(xfer_type == 2'b01, "R4 start when gap met", xfer_type, 1);
      if (p_type == 2'b00 && p_qv && p_void)
        chk(xfer_type == 2'b00, "R8 void dropped", xfer_type, 0);
      if (xfer_type == 2'b01) begin
        starts++;
        chk(p_fcnt >= GAP, "R4 minimum fills", p_fcnt, GAP);
        chk(!frame_done || starts == 1 || ends == starts - 1, "R3 start pairing", ends, starts - 1);
        frame_done = 0;
      end
      if (xfer_more)
        chk(xfer_type == 2'b11, "R7 hint only on end", xfer_type, 3);
      if (xfer_type == 2'b11) begin
        ends++;
        chk(frame_done, "R3 end after final byte", frame_done, 1);
        chk(xfer_more == p_qmore, "R7 hint value", xfer_more, p_qmore);
      end
      fcnt = (xfer_type == 2'b00) ? fcnt + 1 : 0;

      // queue advance
      if (pend_pop) begin
        if (plen(pk) == 0 || wi == plen(pk) - 1) begin
          pk++; wi = 0; hold = pk % 3;
        end else wi++;
      end else if (hold > 0) hold--;

      if (eb_pk >= NPKT && pk >= NPKT && xfer_type == 2'b00) finished = 1;

      // new inputs
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case ((cyc / 150) % 3)
        0: txrdy = 1'b1;
        1: txrdy = lfsr[0];
        default: txrdy = lfsr[0] & lfsr[3];
      endcase
      q_valid = (pk < NPKT) && (hold == 0);
      q_void  = (pk < NPKT) && plen(pk) == 0;
      q_last  = q_void || (pk < NPKT && wi == plen(pk) - 1);
      q_data  = (pk < NPKT && !q_void) ? pbyte(pk, wi) : '0;
      q_more  = ((pk + wi + cyc) % 3) == 0;
      #1;
      pend_pop = q_pop;
      p_type = xfer_type; p_data = xfer_data; p_rdy = txrdy; p_qmore = q_more;
      p_qv = q_valid; p_void = q_void; p_fcnt = fcnt;
      cyc++;
      @(negedge clk);
    end

    chk(cyc < WDOG, "R3 watchdog", cyc, WDOG);
    chk(starts == nfull, "R8 start count", starts, nfull);
    chk(ends == nfull, "R3 end count", ends, nfull);
    chk(eb_pk >= NPKT, "R5 all bytes sent", eb_pk, NPKT);
    chk(xfer_type == 2'b00, "R2 idle fill when empty", xfer_type, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule